// File: doc/BRIEF.md
# Sealed Trip Latch Bank with Minimum Hold

This block holds a bank of five trip channels that advance once per processing interval. The interval is marked by a single-cycle strobe, `tick`. Each channel takes a trip request and its own release input. A shared target-reset input acts on every channel at once. The front-panel button and the serial reset command are merged upstream into that one pin.

A channel's trip output follows its request, so it is asserted in every interval in which the request is present. After a request ends, the output is held for a programmable minimum number of intervals. Once that hold has run out, the output keeps itself asserted through a seal-in path. Only a release or a target-reset breaks the seal, and neither can cut the minimum hold short. A summary output is high whenever any channel is tripping.

All pins are plain level control signals. There is no streamed data, so no valid/ready handshake applies. Inputs are sampled only on cycles with `tick` high, and the outputs change only on the clock edge that ends such a cycle.

Top module: `trip_latch_bank`

## Requirements
- R1: Channel i (bit i of every per-channel vector) has `trip_out[i]` high after any strobe at which `trip_req[i]` was high. This holds whatever the values of `unlatch[i]` and `tgt_reset`.
- R2: A request seen at strobe k with `min_dur` = D (D ≥ 1) keeps `trip_out[i]` high after strobes k through k+D-1, even if no further request arrives.
- R3: Once the minimum hold has run out, a tripped channel stays tripped on every later strobe at which neither `unlatch[i]` nor `tgt_reset` is high.
- R4: At a strobe with no request and no hold left, a high `unlatch[i]` drops only channel i. A high `tgt_reset` drops every channel.
- R5: `unlatch[i]` or `tgt_reset` at a strobe where channel i still has hold intervals left does not drop `trip_out[i]`.
- R6: With `min_dur` of 0 or 1, a request gives no hold beyond the strobes at which the request was high.
- R7: `trip_any` is high exactly when at least one bit of `trip_out` is high.
- R8: A synchronous active-high `rst` clears all trip outputs and all hold timers at the next clock edge.
- R9: On cycles with `tick` low, the inputs are ignored and `trip_out` does not change.
- R10: Every strobe with a request reloads the hold from the `min_dur` value present at that strobe. A later change of `min_dur` does not alter a hold that is already running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle strobe marking a processing interval |
| trip_req | input | 5 | Trip request per channel |
| unlatch | input | 5 | Seal-in release per channel |
| tgt_reset | input | 1 | Shared release for all channels (target reset) |
| min_dur | input | 8 | Minimum trip hold in intervals |
| trip_out | output | 5 | Trip output per channel |
| trip_any | output | 1 | High when any channel trips |

## Verification
Two functions collide in a single interval in two ways. A request can arrive in the same interval as a release, and a release can arrive while the minimum hold is still counting down. The directed part of the bench provokes both on purpose. It asserts the request together with both release inputs, and it holds the release high through every interval of a running hold. The random part then mixes all four inputs at every strobe. Each result is judged against a bench model that gives the request priority, lets the hold cover over a release, and applies the release only to a seal with no hold left.

// File: rtl/trip_pkg.sv
package trip_pkg;
  parameter int unsigned DEF_CHANNELS = 5;
  parameter int unsigned DEF_CNT_W    = 8;

  // Reason a channel is tripping after the coming strobe.
  typedef enum logic [1:0] {
    CAUSE_IDLE = 2'd0,
    CAUSE_REQ  = 2'd1,
    CAUSE_HOLD = 2'd2,
    CAUSE_SEAL = 2'd3
  } trip_cause_e;
endpackage

// File: rtl/trip_hold_timer.sv
module trip_hold_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] min_dur,
  output logic             running
);
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] reload_val;

  // The request interval counts as the first held interval.
  always_comb begin
    reload_val = (min_dur == ZERO) ? ZERO : (min_dur - ONE);
    if (load)              cnt_d = reload_val;
    else if (cnt_q != ZERO) cnt_d = cnt_q - ONE;
    else                   cnt_d = ZERO;
  end

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= ZERO;
    else if (tick) cnt_q <= cnt_d;
  end

  assign running = (cnt_q != ZERO);

  // R9
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt_q));

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && running) |=> (cnt_q == $past(cnt_q) - ONE));

  // R8
  cnt_rst_chk: assert property (@(posedge clk)
    rst |=> (cnt_q == ZERO));
endmodule

// File: rtl/trip_seal_cell.sv
module trip_seal_cell
  import trip_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             req,
  input  logic             unlatch,
  input  logic             tgt_reset,
  input  logic [CNT_W-1:0] min_dur,
  output logic             trip
);
  logic        running;
  logic        trip_q;
  logic        clear;
  trip_cause_e cause_d;

  trip_hold_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .load    (req),
    .min_dur (min_dur),
    .running (running)
  );

  assign clear = unlatch | tgt_reset;

  // Request wins; a running hold masks a release; the seal needs no release.
  always_comb begin
    if (req)                  cause_d = CAUSE_REQ;
    else if (running)         cause_d = CAUSE_HOLD;
    else if (trip_q && !clear) cause_d = CAUSE_SEAL;
    else                      cause_d = CAUSE_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst)       trip_q <= 1'b0;
    else if (tick) trip_q <= (cause_d != CAUSE_IDLE);
  end

  assign trip = trip_q;

  // R1
  req_trip_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && req) |=> trip_q);

  // R5
  hold_masks_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && running) |=> trip_q);

  // R3
  seal_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && trip_q && !unlatch && !tgt_reset) |=> trip_q);

  // R4
  release_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !req && !running && (unlatch || tgt_reset)) |=> !trip_q);

  // R9
  out_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(trip_q));

  // R8
  out_rst_chk: assert property (@(posedge clk)
    rst |=> !trip_q);
endmodule

// File: rtl/trip_summary.sv
module trip_summary #(
  parameter int unsigned N_CH = 5
) (
  input  logic [N_CH-1:0] trip,
  output logic            any
);
  logic [N_CH:0] chain;

  assign chain[0] = 1'b0;
  for (genvar g = 0; g < N_CH; g++) begin : g_or
    assign chain[g+1] = chain[g] | trip[g];
  end
  assign any = chain[N_CH];
endmodule

// File: rtl/trip_latch_bank.sv
module trip_latch_bank
  import trip_pkg::*;
#(
  parameter int unsigned N_CH  = DEF_CHANNELS,
  parameter int unsigned CNT_W = DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [N_CH-1:0]  trip_req,
  input  logic [N_CH-1:0]  unlatch,
  input  logic             tgt_reset,
  input  logic [CNT_W-1:0] min_dur,
  output logic [N_CH-1:0]  trip_out,
  output logic             trip_any
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    trip_seal_cell #(.CNT_W(CNT_W)) u_cell (
      .clk       (clk),
      .rst       (rst),
      .tick      (tick),
      .req       (trip_req[c]),
      .unlatch   (unlatch[c]),
      .tgt_reset (tgt_reset),
      .min_dur   (min_dur),
      .trip      (trip_out[c])
    );
  end

  trip_summary #(.N_CH(N_CH)) u_sum (
    .trip (trip_out),
    .any  (trip_any)
  );

  // R7
  any_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (trip_out != '0) |-> trip_any);

  // R7
  any_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (trip_out == '0) |-> !trip_any);
endmodule

// File: tb/test_trip_latch_bank.sv
module test_trip_latch_bank;
  localparam int NC = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick = 1'b0;
  logic [NC-1:0] trip_req = '0;
  logic [NC-1:0] unlatch = '0;
  logic          tgt_reset = 1'b0;
  logic [7:0]    min_dur = 8'd0;
  logic [NC-1:0] trip_out;
  logic          trip_any;

  int errors = 0;
  int checks = 0;
  logic [NC-1:0] m_trip = '0;
  int            m_cnt [NC];

  always #10 clk = ~clk;

  trip_latch_bank i_trip_latch_bank (
    .clk(clk), .rst(rst), .tick(tick), .trip_req(trip_req),
    .unlatch(unlatch), .tgt_reset(tgt_reset), .min_dur(min_dur),
    .trip_out(trip_out), .trip_any(trip_any)
  );

  function automatic int reload(input logic [7:0] md);
    return (md == 0) ? 0 : int'(md) - 1;
  endfunction

  function automatic logic next_trip(input logic rq, input logic run,
                                     input logic cur, input logic clr);
    return rq | run | (cur & ~clr);
  endfunction

  function automatic logic exp_any(input logic [NC-1:0] t);
    return t != '0;
  endfunction

  task automatic check(input string tag);
    checks++;
    if (trip_out !== m_trip) begin
      errors++;
      $display("FAIL %s trip_out actual=%b expected=%b", tag, trip_out, m_trip);
    end
    checks++;
    if (trip_any !== exp_any(m_trip)) begin
      errors++;
      $display("FAIL %s trip_any actual=%b expected=%b", tag, trip_any, exp_any(m_trip));
    end
  endtask

  task automatic interval(input logic [NC-1:0] rq, input logic [NC-1:0] ul,
                          input logic tr, input logic [7:0] md, input string tag);
    @(negedge clk);
    trip_req = rq; unlatch = ul; tgt_reset = tr; min_dur = md; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    for (int c = 0; c < NC; c++) begin
      m_trip[c] = next_trip(rq[c], m_cnt[c] != 0, m_trip[c], ul[c] | tr);
      if (rq[c])          m_cnt[c] = reload(md);
      else if (m_cnt[c] > 0) m_cnt[c] = m_cnt[c] - 1;
    end
    check(tag);
  endtask

  task automatic idle_cycles(input string tag);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      trip_req = NC'($urandom); unlatch = NC'($urandom);
      tgt_reset = 1'($urandom); min_dur = 8'($urandom); tick = 1'b0;
    end
    @(negedge clk);
    check(tag);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst = 1'b1; tick = 1'b0;
    @(negedge clk);
    m_trip = '0;
    for (int c = 0; c < NC; c++) m_cnt[c] = 0;
    check(tag);
    rst = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int c = 0; c < NC; c++) m_cnt[c] = 0;
    repeat (3) @(negedge clk);
    check("R8 reset state");
    rst = 1'b0;

    // R1 with both releases high, R6 no hold for min_dur 0
    interval(5'b00001, 5'b11111, 1'b1, 8'd0, "R1 req beats clear");
    interval(5'b00000, 5'b00001, 1'b0, 8'd0, "R6 no hold md=0");
    interval(5'b00010, 5'b00010, 1'b0, 8'd1, "R6 req md=1");
    interval(5'b00000, 5'b00010, 1'b0, 8'd1, "R6 no hold md=1");

    // R2 / R5: hold of 4 with release held high throughout
    interval(5'b00100, 5'b00000, 1'b0, 8'd4, "R2 hold start");
    for (int k = 0; k < 4; k++)
      interval(5'b00000, 5'b00100, 1'b1, 8'd4, "R5 clear during hold");

    // R3 seal after hold, then R4 per-channel release
    interval(5'b01010, 5'b00000, 1'b0, 8'd2, "R3 seal start");
    for (int k = 0; k < 5; k++)
      interval(5'b00000, 5'b00000, 1'b0, 8'd2, "R3 sealed");
    interval(5'b00000, 5'b01000, 1'b0, 8'd2, "R4 unlatch one channel");
    idle_cycles("R9 no strobe");
    interval(5'b11111, 5'b00000, 1'b0, 8'd1, "R3 seal all");
    interval(5'b00000, 5'b00000, 1'b1, 8'd1, "R4 target reset all");

    // R10: min_dur change during a running hold
    interval(5'b10000, 5'b00000, 1'b0, 8'd3, "R10 load 3");
    interval(5'b00000, 5'b10000, 1'b0, 8'd9, "R10 md change");
    interval(5'b00000, 5'b10000, 1'b0, 8'd9, "R10 hold end");
    interval(5'b00000, 5'b10000, 1'b0, 8'd9, "R10 released");

    // R8 mid-run reset
    interval(5'b11111, 5'b00000, 1'b0, 8'd6, "R8 arm");
    do_reset("R8 mid-run reset");
    interval(5'b00000, 5'b00000, 1'b0, 8'd6, "R8 timers cleared");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [NC-1:0] rq, ul;
      rq = '0; ul = '0;
      for (int c = 0; c < NC; c++) begin
        rq[c] = ($urandom % 6) == 0;
        ul[c] = ($urandom % 5) == 0;
      end
      interval(rq, ul, ($urandom % 15) == 0, 8'($urandom % 6), "R7 random");
      if (n % 50 == 25) idle_cycles("R9 random gap");
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule